// File: doc/BRIEF.md
# Four-Channel DMA Transfer Engine

This block holds the per-channel transfer state of a four-channel DMA controller and advances it. Each channel keeps a programmed start address, a programmed unit count, a mode byte, two page bytes and a running progress value. When `svc_i` is high, every channel that is unmasked, has a request pending and has not yet moved its full length is served in that same cycle. Each served channel raises its acknowledge bit. Its current full physical address is presented on its slice of `phys_addr_o`. Its progress then advances by one transfer unit.

The parameter `WSHIFT` selects byte channels (0) or 16-bit word channels (1). With word channels, lengths, addresses and readback values are scaled by two. A channel raises its terminal-count bit once its whole length has been moved. A channel set to reload automatically starts over on the cycle after that. A combinational readback port returns one byte of the current address or of the remaining count. A byte-wide page port reaches the page bytes through a fixed scrambled offset map.

Top module: `dma_xfer_engine`

## Requirements
- R1: In a cycle with `svc_i` high, `ack_o[c]` is 1 exactly when `mask_i[c]` is 0, `req_i[c]` is 1 and the progress of channel c is below its length. All such channels are served in the same cycle. With `svc_i` low, `ack_o` is 0.
- R2: Each acknowledge adds `1 << WSHIFT` to the channel's progress on the following clock edge.
- R3: The length is `(count + 1) << WSHIFT`. On the edge where progress reaches the length, `tc_o[c]` becomes 1. Progress then stays put and the channel is no longer acknowledged.
- R4: If mode bit 4 is set, progress returns to 0 one cycle after it reaches the length. `tc_o[c]` stays 1.
- R5: `phys_addr_o` slice c (31 bits) is {high page bits 6..0, page byte, 16-bit effective address}. The effective address is the current address plus the progress, or the current address minus the progress when mode bit 5 is set.
- R6: With `rd_count_sel`=0, the readback is the effective address shifted right by `WSHIFT`. `rd_hi`=0 returns bits 7..0 and `rd_hi`=1 returns bits 15..8.
- R7: With `rd_count_sel`=1, the readback is `(count << WSHIFT) - progress` shifted right by `WSHIFT`, with the same byte selection.
- R8: A configuration write with `cfg_field`=0 (start address) or 1 (count) loads that field and reinitialises the channel. The current address becomes the start address shifted left by `WSHIFT`, progress becomes 0 and `tc_o[c]` is cleared. `cfg_field`=2 loads the mode byte from `cfg_data[7:0]` and nothing else.
- R9: Page offsets 1, 2, 3 and 7 reach channels 2, 3, 1 and 0. `pg_hi` selects the high page byte. Writes to any other offset change nothing, and reads from them return 0.
- R10: After reset every field is 0, `tc_o` is 0 and all readbacks return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_we | input | 1 | Channel configuration write strobe |
| cfg_chan | input | 2 | Channel written |
| cfg_field | input | 2 | 0 start address, 1 count, 2 mode |
| cfg_data | input | 16 | Configuration write data |
| pg_we | input | 1 | Page write strobe |
| pg_hi | input | 1 | Selects the high page byte |
| pg_off | input | 3 | Page port offset |
| pg_wdata | input | 8 | Page write data |
| pg_rdata | output | 8 | Page read data |
| mask_i | input | 4 | Per-channel mask, 1 blocks service |
| req_i | input | 4 | Per-channel pending request |
| svc_i | input | 1 | Service opportunity strobe |
| ack_o | output | 4 | Channels served this cycle |
| tc_o | output | 4 | Terminal-count flags |
| phys_addr_o | output | 124 | Four 31-bit physical addresses, channel 0 in the low bits |
| rd_chan | input | 2 | Readback channel |
| rd_count_sel | input | 1 | 0 address, 1 remaining count |
| rd_hi | input | 1 | Byte select for readback |
| rd_byte | output | 8 | Readback byte |

## Verification
The directed cases use a short incrementing run that hits terminal count and then has an extra strobe refused. A one-unit reload channel tells R4 apart from a plain hold. A decrementing channel that starts at address 1 shows the address wrapping below zero. A write to an unused page offset must leave every page byte intact. Thousands of random cycles then mix masks, requests, strobes, reprogramming of small counts and page accesses. These catch mistakes in simultaneous service, in the priority of reinitialisation over service and in the byte order of readback, checked against a bench model.

// File: rtl/dma_xfer_pkg.sv
package dma_xfer_pkg;
    localparam int NCH   = 4;
    localparam int CHW   = $clog2(NCH);
    localparam int AW    = 16;
    localparam int PGW   = 8;
    localparam int HPW   = 7;
    localparam int PAW   = HPW + PGW + AW;
    localparam int MODEW = 8;
    localparam int MODE_AUTO_BIT = 4;
    localparam int MODE_DOWN_BIT = 5;

    typedef enum logic [1:0] {
        FLD_ADDR  = 2'd0,
        FLD_COUNT = 2'd1,
        FLD_MODE  = 2'd2
    } cfg_field_e;
endpackage

// File: rtl/dma_page_decode.sv
module dma_page_decode
    import dma_xfer_pkg::*;
(
    input  logic [2:0]     off,
    output logic           hit,
    output logic [CHW-1:0] chan
);
    always_comb begin
        hit  = 1'b1;
        chan = '0;
        case (off)
            3'd1:    chan = CHW'(2);
            3'd2:    chan = CHW'(3);
            3'd3:    chan = CHW'(1);
            3'd7:    chan = CHW'(0);
            default: hit  = 1'b0;
        endcase
    end
endmodule

// File: rtl/dma_chan_slice.sv
module dma_chan_slice
    import dma_xfer_pkg::*;
#(
    parameter int WSHIFT = 0
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_we,
    input  logic [1:0]       cfg_field,
    input  logic [AW-1:0]    cfg_data,
    input  logic             pg_we,
    input  logic             pg_hi,
    input  logic [PGW-1:0]   pg_wdata,
    input  logic             mask,
    input  logic             req,
    input  logic             svc,
    output logic             ack,
    output logic             tc,
    output logic [PAW-1:0]   phys_addr,
    output logic [AW-1:0]    rd_addr,
    output logic [AW-1:0]    rd_count,
    output logic [PGW-1:0]   page,
    output logic [PGW-1:0]   hpage
);
    localparam int CURW = AW + WSHIFT;
    localparam int PW   = AW + WSHIFT + 1;
    localparam logic [PW-1:0] STEP = PW'(1) << WSHIFT;

    typedef struct packed {
        logic [AW-1:0]    base_addr;
        logic [AW-1:0]    base_cnt;
        logic [MODEW-1:0] mode;
        logic [PGW-1:0]   page;
        logic [PGW-1:0]   hpage;
        logic [CURW-1:0]  cur;
        logic [PW-1:0]    prog;
        logic             tc;
    } chan_st_t;

    chan_st_t st_d, st_q;
    logic [PW-1:0]   len;
    logic            at_len;
    logic            init;
    logic [CURW-1:0] eff;
    logic [PW-1:0]   left;

    always_comb begin
        len    = (PW'(st_q.base_cnt) + PW'(1)) << WSHIFT;
        at_len = (st_q.prog == len);
        ack    = svc && !mask && req && !at_len;
        init   = cfg_we && (cfg_field == FLD_ADDR || cfg_field == FLD_COUNT);

        if (st_q.mode[MODE_DOWN_BIT])
            eff = st_q.cur - CURW'(st_q.prog);
        else
            eff = st_q.cur + CURW'(st_q.prog);
        left = (PW'(st_q.base_cnt) << WSHIFT) - st_q.prog;

        phys_addr = {st_q.hpage[HPW-1:0], st_q.page, eff[AW-1:0]};
        rd_addr   = eff[WSHIFT +: AW];
        rd_count  = left[WSHIFT +: AW];
        tc        = st_q.tc;
        page      = st_q.page;
        hpage     = st_q.hpage;

        st_d = st_q;
        if (at_len && st_q.mode[MODE_AUTO_BIT])
            st_d.prog = '0;
        if (ack) begin
            st_d.prog = st_q.prog + STEP;
            if (st_d.prog == len)
                st_d.tc = 1'b1;
        end
        if (pg_we) begin
            if (pg_hi) st_d.hpage = pg_wdata;
            else       st_d.page  = pg_wdata;
        end
        if (cfg_we) begin
            case (cfg_field)
                FLD_ADDR:  st_d.base_addr = cfg_data;
                FLD_COUNT: st_d.base_cnt  = cfg_data;
                FLD_MODE:  st_d.mode      = cfg_data[MODEW-1:0];
                default:   ;
            endcase
        end
        if (init) begin
            st_d.cur  = CURW'(st_d.base_addr) << WSHIFT;
            st_d.prog = '0;
            st_d.tc   = 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    p_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
        ack && !init |=> st_q.prog == $past(st_q.prog) + STEP);

    p_no_overrun_r3: assert property (@(posedge clk) disable iff (!rst_n)
        st_q.prog <= len);

    p_tc_at_len_r3: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q.tc) |-> st_q.prog == len);

    p_reload_r4: assert property (@(posedge clk) disable iff (!rst_n)
        at_len && st_q.mode[MODE_AUTO_BIT] && !init |=> st_q.prog == '0 && st_q.tc);

    p_init_r8: assert property (@(posedge clk) disable iff (!rst_n)
        init |=> st_q.prog == '0 && !st_q.tc);
endmodule

// File: rtl/dma_xfer_engine.sv
module dma_xfer_engine
    import dma_xfer_pkg::*;
#(
    parameter int WSHIFT = 0
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               cfg_we,
    input  logic [CHW-1:0]     cfg_chan,
    input  logic [1:0]         cfg_field,
    input  logic [AW-1:0]      cfg_data,
    input  logic               pg_we,
    input  logic               pg_hi,
    input  logic [2:0]         pg_off,
    input  logic [PGW-1:0]     pg_wdata,
    output logic [PGW-1:0]     pg_rdata,
    input  logic [NCH-1:0]     mask_i,
    input  logic [NCH-1:0]     req_i,
    input  logic               svc_i,
    output logic [NCH-1:0]     ack_o,
    output logic [NCH-1:0]     tc_o,
    output logic [NCH*PAW-1:0] phys_addr_o,
    input  logic [CHW-1:0]     rd_chan,
    input  logic               rd_count_sel,
    input  logic               rd_hi,
    output logic [7:0]         rd_byte
);
    logic           pg_hit;
    logic [CHW-1:0] pg_chan;
    logic [AW-1:0]  rd_addr_a  [NCH];
    logic [AW-1:0]  rd_count_a [NCH];
    logic [PGW-1:0] page_a     [NCH];
    logic [PGW-1:0] hpage_a    [NCH];
    logic [AW-1:0]  rd_word;

    dma_page_decode i_pgdec (
        .off  (pg_off),
        .hit  (pg_hit),
        .chan (pg_chan)
    );

    for (genvar c = 0; c < NCH; c++) begin : g_chan
        dma_chan_slice #(.WSHIFT(WSHIFT)) i_slice (
            .clk       (clk),
            .rst_n     (rst_n),
            .cfg_we    (cfg_we && cfg_chan == CHW'(c)),
            .cfg_field (cfg_field),
            .cfg_data  (cfg_data),
            .pg_we     (pg_we && pg_hit && pg_chan == CHW'(c)),
            .pg_hi     (pg_hi),
            .pg_wdata  (pg_wdata),
            .mask      (mask_i[c]),
            .req       (req_i[c]),
            .svc       (svc_i),
            .ack       (ack_o[c]),
            .tc        (tc_o[c]),
            .phys_addr (phys_addr_o[c*PAW +: PAW]),
            .rd_addr   (rd_addr_a[c]),
            .rd_count  (rd_count_a[c]),
            .page      (page_a[c]),
            .hpage     (hpage_a[c])
        );
    end

    always_comb begin
        rd_word = rd_count_sel ? rd_count_a[rd_chan] : rd_addr_a[rd_chan];
        rd_byte = rd_hi ? rd_word[15:8] : rd_word[7:0];
        if (!pg_hit)    pg_rdata = '0;
        else if (pg_hi) pg_rdata = hpage_a[pg_chan];
        else            pg_rdata = page_a[pg_chan];
    end

    p_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !svc_i |-> ack_o == '0);

    p_masked_r1: assert property (@(posedge clk) disable iff (!rst_n)
        (ack_o & (mask_i | ~req_i)) == '0);

    p_bad_off_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !pg_hit |-> pg_rdata == '0);
endmodule

// File: tb/test_dma_xfer_engine.sv
module test_dma_xfer_engine;
    localparam int S = 0;

    logic         clk = 0;
    logic         rst_n = 0;
    logic         cfg_we = 0;
    logic [1:0]   cfg_chan = 0, cfg_field = 0;
    logic [15:0]  cfg_data = 0;
    logic         pg_we = 0, pg_hi = 0;
    logic [2:0]   pg_off = 0;
    logic [7:0]   pg_wdata = 0, pg_rdata;
    logic [3:0]   mask_i = 4'hF, req_i = 0, ack_o, tc_o;
    logic         svc_i = 0;
    logic [123:0] phys_addr_o;
    logic [1:0]   rd_chan = 0;
    logic         rd_count_sel = 0, rd_hi = 0;
    logic [7:0]   rd_byte;

    int nchk = 0, nfail = 0;

    logic [31:0] m_ba [4], m_bc [4], m_md [4], m_pg [4], m_hp [4];
    logic [31:0] m_cur [4], m_prog [4];
    logic        m_tc [4];

    always #5 clk = ~clk;

    dma_xfer_engine #(.WSHIFT(S)) i_dma_xfer_engine (.*);

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        nchk++;
        if (act !== exp) begin
            nfail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    function automatic logic [31:0] f_len(int c);
        return (m_bc[c] + 1) << S;
    endfunction
    function automatic logic [31:0] f_eff(int c);
        logic [31:0] e;
        e = m_md[c][5] ? m_cur[c] - m_prog[c] : m_cur[c] + m_prog[c];
        return e & ((32'd1 << (16 + S)) - 1);
    endfunction
    function automatic logic [31:0] f_phys(int c);
        return {1'b0, m_hp[c][6:0], m_pg[c][7:0], f_eff(c)[15:0]};
    endfunction
    function automatic logic [31:0] f_rd(int c, logic cs, logic hi);
        logic [31:0] v;
        if (cs) v = (((m_bc[c] << S) - m_prog[c]) >> S) & 32'hFFFF;
        else    v = (f_eff(c) >> S) & 32'hFFFF;
        return hi ? {24'd0, v[15:8]} : {24'd0, v[7:0]};
    endfunction
    function automatic int f_pgmap(logic [2:0] off);
        case (off)
            3'd1: return 2;
            3'd2: return 3;
            3'd3: return 1;
            3'd7: return 0;
            default: return -1;
        endcase
    endfunction
    function automatic logic f_elig(int c);
        return svc_i && !mask_i[c] && req_i[c] && (m_prog[c] != f_len(c));
    endfunction

    task automatic model_reset();
        for (int c = 0; c < 4; c++) begin
            m_ba[c] = 0; m_bc[c] = 0; m_md[c] = 0; m_pg[c] = 0; m_hp[c] = 0;
            m_cur[c] = 0; m_prog[c] = 0; m_tc[c] = 0;
        end
    endtask

    task automatic compare_all();
        logic [3:0] ea, et;
        int pc;
        for (int c = 0; c < 4; c++) begin
            ea[c] = f_elig(c);
            et[c] = m_tc[c];
            check("R5 phys", {1'b0, phys_addr_o[c*31 +: 31]}, f_phys(c));
        end
        check("R1 ack", {28'd0, ack_o}, {28'd0, ea});
        check("R3 tc", {28'd0, tc_o}, {28'd0, et});
        check(rd_count_sel ? "R7 count readback" : "R6 addr readback",
              {24'd0, rd_byte}, f_rd(rd_chan, rd_count_sel, rd_hi));
        pc = f_pgmap(pg_off);
        check("R9 page read", {24'd0, pg_rdata},
              pc < 0 ? 32'd0 : (pg_hi ? m_hp[pc] : m_pg[pc]));
    endtask

    task automatic model_step();
        logic el [4];
        int pc;
        for (int c = 0; c < 4; c++) el[c] = f_elig(c);
        pc = f_pgmap(pg_off);
        for (int c = 0; c < 4; c++) begin
            if (m_prog[c] == f_len(c) && m_md[c][4]) m_prog[c] = 0;
            if (el[c]) begin
                m_prog[c] = m_prog[c] + (32'd1 << S);
                if (m_prog[c] == f_len(c)) m_tc[c] = 1;
            end
            if (pg_we && pc == c) begin
                if (pg_hi) m_hp[c] = {24'd0, pg_wdata};
                else       m_pg[c] = {24'd0, pg_wdata};
            end
            if (cfg_we && cfg_chan == 2'(c)) begin
                if (cfg_field == 0) m_ba[c] = {16'd0, cfg_data};
                if (cfg_field == 1) m_bc[c] = {16'd0, cfg_data};
                if (cfg_field == 2) m_md[c] = {24'd0, cfg_data[7:0]};
                if (cfg_field <= 1) begin
                    m_cur[c] = (m_ba[c] << S) & ((32'd1 << (16 + S)) - 1);
                    m_prog[c] = 0;
                    m_tc[c] = 0;
                end
            end
        end
    endtask

    task automatic cycle();
        #1;
        compare_all();
        @(posedge clk);
        model_step();
        @(negedge clk);
    endtask

    task automatic idle();
        cfg_we = 0; pg_we = 0; svc_i = 0;
    endtask

    task automatic cfg(int c, int f, int d);
        idle();
        cfg_we = 1; cfg_chan = 2'(c); cfg_field = 2'(f); cfg_data = 16'(d);
        cycle();
        idle();
    endtask

    task automatic pgw(int off, logic hi, int d);
        idle();
        pg_we = 1; pg_off = 3'(off); pg_hi = hi; pg_wdata = 8'(d);
        cycle();
        idle();
    endtask

    task automatic serve(logic [3:0] rq);
        idle();
        mask_i = 0; req_i = rq; svc_i = 1;
        cycle();
        idle();
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        nfail++;
        $display("FAIL watchdog actual=running expected=done");
        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end

    initial begin
        model_reset();
        repeat (3) @(negedge clk);
        rst_n = 1;
        #1;
        check("R10 tc after reset", {28'd0, tc_o}, 0);
        check("R10 readback after reset", {24'd0, rd_byte}, 0);
        pg_off = 3'd1; #1;
        check("R10 page after reset", {24'd0, pg_rdata}, 0);
        cycle();

        // R5/R9: channel 1 via page offset 3, incrementing, count 2
        pgw(3, 0, 8'hAB);
        pgw(3, 1, 8'hFF);
        cfg(1, 0, 16'h1234);
        cfg(1, 1, 2);
        serve(4'b0010);
        check("R5 phys after one unit", {1'b0, phys_addr_o[31 +: 31]},
              {1'b0, 7'h7F, 8'hAB, 16'h1235});
        check("R2 progress step", m_prog[1], 1 << S);
        serve(4'b0010);
        serve(4'b0010);
        #1;
        check("R3 tc after full length", {31'd0, tc_o[1]}, 1);
        svc_i = 1; req_i = 4'b0010; #1;
        check("R3 no ack past length", {31'd0, ack_o[1]}, 0);
        cycle();
        idle();

        // R4: channel 2, reload, count 0
        cfg(2, 2, 8'h10);
        cfg(2, 1, 0);
        serve(4'b0100);
        check("R4 tc set at reload point", {31'd0, tc_o[2]}, 1);
        cycle();
        rd_chan = 2; rd_count_sel = 1; rd_hi = 0; #1;
        check("R4 progress reloaded", {24'd0, rd_byte}, 8'(0 - 0));
        svc_i = 1; req_i = 4'b0100; mask_i = 0; #1;
        check("R4 served again after reload", {31'd0, ack_o[2]}, 1);
        cycle();
        idle();

        // R8 and decrement wrap: channel 3
        cfg(3, 2, 8'h20);
        cfg(3, 0, 1);
        cfg(3, 1, 3);
        serve(4'b1000);
        serve(4'b1000);
        rd_chan = 3; rd_count_sel = 0; rd_hi = 1; #1;
        check("R6 decrement wrap high byte", {24'd0, rd_byte}, 8'hFF);
        cfg(3, 0, 16'h4000);
        rd_count_sel = 1; rd_hi = 0; #1;
        check("R8 reinit count readback", {24'd0, rd_byte}, 8'h03);
        check("R8 tc cleared", {31'd0, tc_o[3]}, 0);

        // R9: bad offset write leaves pages intact
        pgw(5, 0, 8'h55);
        pg_off = 3; pg_hi = 0; #1;
        check("R9 ignored offset keeps page", {24'd0, pg_rdata}, 8'hAB);

        // random phase
        void'($urandom(32'h1F2E3D4C));
        for (int i = 0; i < 4000; i++) begin
            svc_i = $urandom_range(0, 1);
            mask_i = 4'($urandom);
            req_i = 4'($urandom);
            cfg_we = ($urandom_range(0, 9) == 0);
            cfg_chan = 2'($urandom);
            cfg_field = 2'($urandom_range(0, 2));
            case (cfg_field)
                2'd1:    cfg_data = 16'($urandom_range(0, 7));
                2'd2:    cfg_data = 16'({$urandom_range(0, 3), 4'h0});
                default: cfg_data = 16'($urandom);
            endcase
            pg_we = ($urandom_range(0, 9) == 0);
            pg_off = 3'($urandom);
            pg_hi = 1'($urandom);
            pg_wdata = 8'($urandom);
            rd_chan = 2'($urandom);
            rd_count_sel = 1'($urandom);
            rd_hi = 1'($urandom);
            cycle();
        end

        $display("[TB] %0d tests run, %0d failed", nchk, nfail);
        $finish;
    end
endmodule